// File: doc/BRIEF.md
# Pipelined Register Slave with Programmable Wait States

This block is a single memory-mapped slave on a pipelined on-chip bus in the AHB-Lite style. It holds a small array of data words. In the address phase it samples the select, transfer type, address, direction and size. It acts on them in the data phase that follows. A configuration input sets how many wait states the slave inserts into every good access. During those cycles it holds its ready output low and keeps the captured address.

Some accesses are faulty: an address that is not aligned to its size, an unsupported size, or an address inside a configured forbidden byte window. The slave answers a faulty access with the two-cycle error sequence and leaves its storage as it was. Idle and busy transfer types are not real accesses. They receive an immediate okay response.

Top module: `pipe_wait_slave`

## Requirements
- R1: After reset the slave drives ready high, response OKAY (0), read data zero, and every stored word is zero.
- R2: Control is captured only at a clock edge where `bus_ready_in` is high, `bus_sel` is high and `bus_trans` is NONSEQ (2'b10) or SEQ (2'b11). The captured values govern the data phase that starts in the next cycle.
- R3: A good access captured with `wait_cfg` = N holds `bus_ready_out` low with OKAY for exactly N cycles. It then raises ready with OKAY for one cycle, and the transfer completes in that cycle.
- R4: On a completing read, `bus_rdata` carries the whole stored word selected by address bits [5:2]. In every other cycle it is zero.
- R5: A write is applied at the end of its completing cycle, using the captured address and size and little-endian byte lanes. A byte write (size 0) updates lane addr[1:0]. A halfword write (size 1) updates lanes 2*addr[1] and 2*addr[1]+1. A word write (size 2) updates all four lanes.
- R6: An error response takes two cycles. In the first, the response is ERROR (1) and ready is low. In the second, the response is ERROR and ready is high. No wait states come before it.
- R7: A halfword access with addr[0]=1, a word access with addr[1:0]!=0, or any size above 2 gets the error response.
- R8: Any access whose byte address lies within the inclusive forbidden window 0x30..0x37 gets the error response.
- R9: An errored write leaves every stored word unchanged.
- R10: If a ready-high edge sees no real access (select low, or transfer type IDLE 2'b00 or BUSY 2'b01), the next cycle has ready high with OKAY, and no stored word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Slave selected for this address phase |
| bus_trans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| bus_addr | input | 6 | Byte address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 3 | log2 of the access width in bytes |
| bus_wdata | input | 32 | Write data, valid in the data phase |
| bus_ready_in | input | 1 | Bus-wide ready; qualifies address capture |
| wait_cfg | input | 3 | Wait states to insert per good access |
| bus_ready_out | output | 1 | Low while the data phase is stretched |
| bus_resp | output | 1 | 0 = OKAY, 1 = ERROR |
| bus_rdata | output | 32 | Read data on the completing read cycle |

## Verification
On every cycle, the assertions check the shape of the error response: the low-ready error cycle is always followed by the high-ready error cycle, and the high-ready one is always preceded by the low-ready one. They also check that a stretch of low ready with OKAY never runs longer than the largest wait count, that read data stays zero outside a completing okay cycle, and that an edge with no real access is followed by a zero-wait OKAY. Other behaviour can only be shown by the bench's sweeps: the exact wait count for each setting, the byte-lane merging for every address and size, the detection of misaligned and forbidden accesses, and the fact that an errored or ignored access leaves storage untouched. The sweeps show these by reading the stored words back and comparing them with an arithmetic model.

// File: rtl/pslv_pkg.sv
// Shared types for the pipelined register slave.
// Assumes the two-bit transfer-type encoding used on the bus.
package pslv_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic [2:0] {
        PH_IDLE,   // no data phase in progress, ready high
        PH_WAIT,   // stretching a good access
        PH_ERR1,   // error, ready low
        PH_ERR2,   // error, ready high
        PH_LAST    // completing cycle of a good access
    } phase_t;
endpackage

// File: rtl/pslv_capture.sv
// Address-phase capture stage.
// Registers address, direction and size when a real access is accepted.
// Classifies the incoming access as faulty (misaligned, oversize, forbidden).
// Assumes bus_ready_in is the bus-wide ready seen by every slave.
module pslv_capture #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int FORBID_LO = 'h30,
    parameter int FORBID_HI = 'h37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [1:0]        trans,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [2:0]        size,
    input  logic              ready_in,
    output logic              take,
    output logic              fault,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_write,
    output logic [2:0]        cap_size
);
    import pslv_pkg::*;

    localparam int LANE_BITS = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(FORBID_LO);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(FORBID_HI);

    logic              real_xfer;
    logic              oversize;
    logic              misalign;
    logic              forbidden;
    logic [ADDR_W-1:0] align_mask;

    // Decide whether this edge accepts a real access
    always_comb begin
        real_xfer = (trans == TR_NONSEQ) || (trans == TR_SEQ);
        take      = ready_in && sel && real_xfer;
    end

    // Classify the incoming access
    always_comb begin
        oversize   = size > 3'(LANE_BITS);
        align_mask = (ONE_A << size) - ONE_A;
        misalign   = (addr & align_mask) != '0;
        forbidden  = (addr >= LO_A) && (addr <= HI_A);
        fault      = oversize || misalign || forbidden;
    end

    // Hold the accepted control for the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_write <= 1'b0;
            cap_size  <= '0;
        end else if (take) begin
            cap_addr  <= addr;
            cap_write <= write;
            cap_size  <= size;
        end
    end
endmodule

// File: rtl/pslv_phase.sv
// Data-phase sequencer.
// Counts programmed wait states for good accesses and plays the two-cycle
// error sequence for faulty ones. Assumes take is only raised on ready-high edges.
module pslv_phase #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              fault,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              ready_out,
    output logic              resp_err,
    output logic              done_ok
);
    import pslv_pkg::*;

    localparam logic [WAIT_W-1:0] ONE_W = 1;

    phase_t            state;
    phase_t            nxt;
    logic [WAIT_W-1:0] cnt;

    // Next-phase selection
    always_comb begin
        nxt = PH_IDLE;
        case (state)
            PH_WAIT: nxt = (cnt == ONE_W) ? PH_LAST : PH_WAIT;
            PH_ERR1: nxt = PH_ERR2;
            default: begin
                if (take) begin
                    if (fault)              nxt = PH_ERR1;
                    else if (wait_cfg == '0) nxt = PH_LAST;
                    else                     nxt = PH_WAIT;
                end
            end
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    // Wait-state down counter
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (take && !fault && state != PH_WAIT && state != PH_ERR1)
                                             cnt <= wait_cfg;
        else if (state == PH_WAIT)           cnt <= cnt - ONE_W;
    end

    // Bus response outputs
    always_comb begin
        ready_out = !((state == PH_WAIT) || (state == PH_ERR1));
        resp_err  = (state == PH_ERR1) || (state == PH_ERR2);
        done_ok   = (state == PH_LAST);
    end
endmodule

// File: rtl/pslv_regfile.sv
// Word-organised storage with byte-lane writes.
// Lanes are little-endian; the lane strobes follow address and size.
// Assumes the caller only enables a write for a good, aligned access.
module pslv_regfile #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);
    localparam int IDX_W     = $clog2(NUM_WORDS);

    logic [DATA_W-1:0]    mem [NUM_WORDS];
    logic [LANES-1:0]     stb;
    logic [IDX_W-1:0]     idx;
    logic [LANE_BITS-1:0] lane_lo;

    assign idx     = addr[LANE_BITS +: IDX_W];
    assign lane_lo = addr[LANE_BITS-1:0];

    // One strobe per lane: lane is in the naturally aligned group of the access
    for (genvar g = 0; g < LANES; g++) begin : g_stb
        assign stb[g] = (LANE_BITS'(g) >> size) == (lane_lo >> size);
    end

    // Storage update with lane merging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++)
                if (stb[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Read the selected word
    assign rword = mem[idx];
endmodule

// File: rtl/pipe_wait_slave.sv
// Pipelined register slave with programmable wait states.
// Captures address-phase control, stretches good accesses by wait_cfg cycles,
// answers faulty accesses with the two-cycle error, ignores IDLE/BUSY beats.
// Assumes a single data phase is outstanding, per the bus pipeline.
module pipe_wait_slave #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int WAIT_W    = 3,
    parameter int FORBID_LO = 'h30,
    parameter int FORBID_HI = 'h37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [1:0]        bus_trans,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready_in,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              bus_ready_out,
    output logic              bus_resp,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              take;
    logic              fault;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_write;
    logic [2:0]        cap_size;
    logic              done_ok;
    logic [DATA_W-1:0] rword;

    pslv_capture #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FORBID_LO(FORBID_LO), .FORBID_HI(FORBID_HI)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .trans(bus_trans),
        .addr(bus_addr), .write(bus_write), .size(bus_size),
        .ready_in(bus_ready_in), .take(take), .fault(fault),
        .cap_addr(cap_addr), .cap_write(cap_write), .cap_size(cap_size)
    );

    pslv_phase #(.WAIT_W(WAIT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .take(take), .fault(fault),
        .wait_cfg(wait_cfg), .ready_out(bus_ready_out),
        .resp_err(bus_resp), .done_ok(done_ok)
    );

    pslv_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(done_ok && cap_write),
        .addr(cap_addr), .size(cap_size), .wdata(bus_wdata), .rword(rword)
    );

    // Read data only on the completing cycle of a good read
    assign bus_rdata = (done_ok && !cap_write) ? rword : '0;
endmodule

// File: rtl/pipe_wait_slave_checker.sv
// Cycle-level protocol checks for pipe_wait_slave, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module pipe_wait_slave_checker #(
    parameter int DATA_W = 32,
    parameter int WAIT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [1:0]        bus_trans,
    input logic              bus_ready_in,
    input logic              bus_ready_out,
    input logic              bus_resp,
    input logic [DATA_W-1:0] bus_rdata
);
    localparam int MAX_WAIT = (1 << WAIT_W) - 1;

    logic [WAIT_W:0] low_run;

    // Length of the current run of low-ready OKAY cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                         low_run <= '0;
        else if (!bus_ready_out && !bus_resp) low_run <= low_run + 1'b1;
        else                                low_run <= '0;
    end

    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && !bus_ready_out) |=> (bus_resp && bus_ready_out)); // R6
    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && bus_ready_out) |-> $past(bus_resp && !bus_ready_out)); // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run <= (WAIT_W+1)'(MAX_WAIT))); // R3
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready_out || bus_resp) |-> (bus_rdata == '0)); // R4
    AST_NO_ACCESS_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_in && !(bus_sel && bus_trans[1])) |=> (bus_ready_out && !bus_resp)); // R10
endmodule

bind pipe_wait_slave pipe_wait_slave_checker #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_trans(bus_trans),
    .bus_ready_in(bus_ready_in), .bus_ready_out(bus_ready_out),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata)
);

// File: tb/test_pipe_wait_slave.sv
module test_pipe_wait_slave;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [1:0]  bus_trans = 2'b00;
    logic [5:0]  bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready_in;
    logic [2:0]  wait_cfg = '0;
    logic        bus_ready_out;
    logic        bus_resp;
    logic [31:0] bus_rdata;

    logic [31:0] model [16];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    assign bus_ready_in = bus_ready_out;

    pipe_wait_slave i_pipe_wait_slave (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_trans(bus_trans),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ready_in(bus_ready_in), .wait_cfg(wait_cfg),
        .bus_ready_out(bus_ready_out), .bus_resp(bus_resp), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic bit is_fault(input logic [5:0] a, input logic [2:0] sz);
        bit mis = (sz == 3'd1 && a[0]) || (sz == 3'd2 && a[1:0] != 2'b00);
        return (sz > 3'd2) || mis || (a >= 6'h30 && a <= 6'h37);
    endfunction

    // Merge a write into the model per the lane rules of R5
    task automatic model_write(input logic [5:0] a, input logic [2:0] sz,
                               input logic [31:0] d);
        for (int b = 0; b < 4; b++) begin
            bit hit = (sz == 3'd2) || (sz == 3'd1 && (b / 2) == int'(a[1])) ||
                      (sz == 3'd0 && b == int'(a[1:0]));
            if (hit) model[a[5:2]][8*b +: 8] = d[8*b +: 8];
        end
    endtask

    // One non-pipelined transfer: address phase, then the whole data phase
    task automatic xfer(input logic [5:0] a, input bit wr, input logic [2:0] sz,
                        input logic [31:0] d, input logic [2:0] wt);
        bit exp_err = is_fault(a, sz);
        bit ok = 1;
        int lows = 0;
        @(negedge clk);
        wait_cfg = wt; bus_sel = 1'b1; bus_trans = 2'b10;
        bus_addr = a; bus_write = wr; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_trans = 2'b00;
        if (exp_err) begin
            // R6/R7/R8: error first cycle, ready low
            check(bus_resp && !bus_ready_out, "R6 R7 R8 error cycle 1",
                  {30'd0, bus_resp, bus_ready_out}, 32'h2);
            @(negedge clk);
            check(bus_resp && bus_ready_out, "R6 error cycle 2",
                  {30'd0, bus_resp, bus_ready_out}, 32'h3);
        end else begin
            for (int i = 0; i < int'(wt); i++) begin
                if (bus_ready_out || bus_resp) ok = 0;
                else lows++;
                @(negedge clk);
            end
            // R3: exactly wt low cycles, then ready high with OKAY
            check(ok && bus_ready_out && !bus_resp, "R3 wait count",
                  32'(lows), 32'(wt));
            if (!wr)
                check(bus_rdata === model[a[5:2]], "R4 read data",
                      bus_rdata, model[a[5:2]]);
            else begin
                check(bus_rdata === 32'd0, "R4 rdata zero on write", bus_rdata, 32'd0);
                model_write(a, sz, d);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        for (int w = 0; w < 16; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_ready_out && !bus_resp && bus_rdata == 0, "R1 during reset",
              bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ready_out && !bus_resp, "R1 after reset",
              {30'd0, bus_ready_out, bus_resp}, 32'h2);
        for (int w = 0; w < 16; w++)
            if (w != 12 && w != 13) xfer(6'(w*4), 0, 3'd2, 0, 3'd0);

        // R3/R2: every wait setting on writes and reads
        for (int w = 0; w < 8; w++) begin
            xfer(6'(w*4), 1, 3'd2, 32'h1000_0000 + 32'(w) * 32'h0101_0101, 3'(w));
            xfer(6'(w*4), 0, 3'd2, 32'hDEAD_BEEF, 3'(7 - w));
        end

        // R5/R7/R8/R9: every address and size, then read back the word
        for (int a = 0; a < 64; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                logic [31:0] d = 32'hA500_0000 ^ (32'(a) * 32'h0103_0507) ^ 32'(sz);
                xfer(6'(a), 1, 3'(sz), d, 3'((a + sz) % 8));
                xfer(6'(a & 6'h3C), 0, 3'd2, 0, 3'(sz));
            end
        end

        // R10: BUSY, IDLE and unselected beats do nothing
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            bus_sel = (k != 2); bus_trans = (k == 0) ? 2'b01 : (k == 1 ? 2'b00 : 2'b10);
            bus_addr = 6'h04; bus_write = 1'b1; bus_size = 3'd2; bus_wdata = 32'hFFFF_FFFF;
            wait_cfg = 3'd5;
            @(negedge clk);
            check(bus_ready_out && !bus_resp, "R10 zero-wait okay",
                  {30'd0, bus_ready_out, bus_resp}, 32'h2);
            bus_sel = 1'b0; bus_trans = 2'b00;
        end
        xfer(6'h04, 0, 3'd2, 0, 3'd1);  // R10 word unchanged
        finish_run();
    end
endmodule